// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which parts of a small processor core receive a clock while the core runs from a single high-frequency oscillator. It has three modes. In the running mode everything is clocked. In the light idle mode the CPU is stopped and the peripherals keep their clock. In the deep idle mode only the time-base timer keeps its clock. Software enters the idle modes by writing a one-cycle idle strobe or halt strobe. The block also divides the clock by four to produce the machine-cycle strobe.

The light idle mode ends as soon as any interrupt request is pending. The deep idle mode ignores interrupt requests. It ends on the first falling edge of the time-base timer's source clock, which is synchronised by two flops. On every wake-up the resume flag records the interrupt master enable. The core uses this flag to choose between taking the interrupt and continuing with the next instruction. If the timer enable was set when the block entered deep idle, a one-cycle pulse sets the time-base interrupt latch after the return to the running mode.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the CPU, peripheral and timer clock enables are 1, and the resume flag and the timer interrupt pulse are 0.
- R2: The machine-cycle strobe is high for one cycle in every 4. It is first high in the 3rd cycle after reset is released.
- R3: In the running mode, an idle strobe without a halt strobe sets the CPU enable to 0 in the next cycle. The peripheral and timer enables stay 1.
- R4: In light idle, if any bit of the pending-request vector is 1, the CPU enable returns to 1 in the next cycle. If a request is already pending in the cycle the block enters light idle, light idle lasts exactly one cycle.
- R5: At every wake-up, the resume flag takes the value of the interrupt master enable in the cycle that ends the idle mode. The flag keeps that value until the next wake-up.
- R6: In the running mode, a halt strobe sets the CPU and peripheral enables to 0 in the next cycle. The timer enable stays 1.
- R7: In deep idle, pending requests and rising edges of the timer source have no effect. A falling edge of the timer source makes the CPU and peripheral enables 1 again in the third cycle after the edge.
- R8: Entry to and exit from deep idle do not depend on the timer enable input.
- R9: The timer interrupt pulse is high for exactly one cycle, in the first running cycle after deep idle. This happens if and only if the timer enable was 1 in the cycle the halt strobe was taken. Later changes to the timer enable do not matter.
- R10: If the idle strobe and the halt strobe arrive in the same cycle, the block enters deep idle.
- R11: Idle and halt strobes that arrive while the block is in an idle mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-frequency clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | One-cycle strobe requesting light idle |
| halt_req_i | input | 1 | One-cycle strobe requesting deep idle |
| imf_i | input | 1 | Interrupt master enable |
| irq_pend_i | input | NUM_IRQ | Pending interrupt requests |
| tbt_src_i | input | 1 | Time-base timer source clock (asynchronous) |
| tbt_en_i | input | 1 | Time-base timer enable |
| mcyc_stb_o | output | 1 | Machine-cycle strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| tbt_clk_en_o | output | 1 | Time-base timer clock enable |
| tbt_irq_set_o | output | 1 | One-cycle pulse that sets the time-base interrupt latch |
| resume_take_irq_o | output | 1 | 1: take the interrupt on resume; 0: continue with the next instruction |

## Verification
The mode is held in a single register, so each enable changes one rising edge after the strobe or request that causes it. The checks sample at the falling edge that follows that rising edge. A deep-idle exit goes through two synchroniser flops and one mode update, so its result is due three rising edges after the timer source falls. The bench checks that the enables are still 0 after two rising edges and that the enables and the interrupt pulse appear after the third. The pulse is sampled once more one cycle later to show that it has dropped.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    MODE_RUN   = 3'b001,
    MODE_LIGHT = 3'b010,
    MODE_DEEP  = 3'b100
  } mode_e;
endpackage

// File: rtl/lpm_mcyc_div.sv
module lpm_mcyc_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = (cnt_q == LAST);
endmodule

// File: rtl/lpm_edge_sync.sv
module lpm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic arm_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  // only meaningful while the deep-idle exit is armed
  assign fall_o = arm_i & prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idle_req_i,
  input  logic  halt_req_i,
  input  logic  irq_any_i,
  input  logic  tbt_fall_i,
  input  logic  imf_i,
  input  logic  tbt_en_i,
  output mode_e mode_o,
  output logic  resume_o,
  output logic  tbt_set_o
);
  mode_e mode_q, mode_d;
  logic  resume_q, resume_d;
  logic  tbt_set_q, tbt_set_d;
  logic  tbt_lat_q, tbt_lat_d;

  always_comb begin
    mode_d    = mode_q;
    resume_d  = resume_q;
    tbt_set_d = 1'b0;
    tbt_lat_d = tbt_lat_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (halt_req_i) begin
          mode_d    = MODE_DEEP;
          tbt_lat_d = tbt_en_i;
        end else if (idle_req_i) begin
          mode_d = MODE_LIGHT;
        end
      end
      MODE_LIGHT: begin
        if (irq_any_i) begin
          mode_d   = MODE_RUN;
          resume_d = imf_i;
        end
      end
      MODE_DEEP: begin
        if (tbt_fall_i) begin
          mode_d    = MODE_RUN;
          resume_d  = imf_i;
          tbt_set_d = tbt_lat_q;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN;
      resume_q  <= 1'b0;
      tbt_set_q <= 1'b0;
      tbt_lat_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      resume_q  <= resume_d;
      tbt_set_q <= tbt_set_d;
      tbt_lat_q <= tbt_lat_d;
    end
  end

  assign mode_o    = mode_q;
  assign resume_o  = resume_q;
  assign tbt_set_o = tbt_set_q;
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int MCYC_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idle_req_i,
  input  logic               halt_req_i,
  input  logic               imf_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic               tbt_src_i,
  input  logic               tbt_en_i,
  output logic               mcyc_stb_o,
  output logic               cpu_clk_en_o,
  output logic               periph_clk_en_o,
  output logic               tbt_clk_en_o,
  output logic               tbt_irq_set_o,
  output logic               resume_take_irq_o
);
  mode_e mode;
  logic  tbt_fall;
  logic  irq_any;

  assign irq_any = |irq_pend_i;

  lpm_mcyc_div #(.DIV(MCYC_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_o  (mcyc_stb_o)
  );

  lpm_edge_sync #(.STAGES(SYNC_STAGES)) u_tbt_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tbt_src_i),
    .arm_i  (mode == MODE_DEEP),
    .fall_o (tbt_fall)
  );

  lpm_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_req_i (idle_req_i),
    .halt_req_i (halt_req_i),
    .irq_any_i  (irq_any),
    .tbt_fall_i (tbt_fall),
    .imf_i      (imf_i),
    .tbt_en_i   (tbt_en_i),
    .mode_o     (mode),
    .resume_o   (resume_take_irq_o),
    .tbt_set_o  (tbt_irq_set_o)
  );

  assign cpu_clk_en_o    = (mode == MODE_RUN);
  assign periph_clk_en_o = (mode != MODE_DEEP);
  assign tbt_clk_en_o    = 1'b1;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               idle_req_i,
  input logic               halt_req_i,
  input logic               imf_i,
  input logic [NUM_IRQ-1:0] irq_pend_i,
  input logic               tbt_src_i,
  input logic               tbt_en_i,
  input logic               mcyc_stb_o,
  input logic               cpu_clk_en_o,
  input logic               periph_clk_en_o,
  input logic               tbt_clk_en_o,
  input logic               tbt_irq_set_o,
  input logic               resume_take_irq_o
);
  a_r2_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcyc_stb_o |=> !mcyc_stb_o);

  a_r3_light_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && idle_req_i && !halt_req_i) |=> (!cpu_clk_en_o && periph_clk_en_o));

  a_r4_light_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && periph_clk_en_o && (|irq_pend_i)) |=> cpu_clk_en_o);

  a_r11_light_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && periph_clk_en_o && !(|irq_pend_i)) |=> (!cpu_clk_en_o && periph_clk_en_o));

  a_r5_resume_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> (resume_take_irq_o == $past(imf_i)));

  a_r6_deep_gating: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !periph_clk_en_o |-> (tbt_clk_en_o && !cpu_clk_en_o));

  a_r10_halt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && halt_req_i) |=> !periph_clk_en_o);

  a_r9_pulse_after_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbt_irq_set_o |-> (cpu_clk_en_o && $past(!periph_clk_en_o)));

  a_r9_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbt_irq_set_o |=> !tbt_irq_set_o);
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;
  localparam int NUM_IRQ = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               idle_req = 1'b0, halt_req = 1'b0, imf = 1'b0;
  logic [NUM_IRQ-1:0] irq = '0;
  logic               tbt_src = 1'b1, tbt_en = 1'b0;
  logic mcyc, cpu_en, per_en, tbt_ck, tbt_set, resume;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic exp_resume = 1'b0;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl #(.NUM_IRQ(NUM_IRQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .idle_req_i(idle_req), .halt_req_i(halt_req),
    .imf_i(imf), .irq_pend_i(irq), .tbt_src_i(tbt_src), .tbt_en_i(tbt_en),
    .mcyc_stb_o(mcyc), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en),
    .tbt_clk_en_o(tbt_ck), .tbt_irq_set_o(tbt_set), .resume_take_irq_o(resume)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // enables packed as {cpu, periph, timer}
  function automatic int en3();
    return {29'd0, cpu_en, per_en, tbt_ck};
  endfunction

  task automatic enter_light();
    idle_req = 1'b1; step(1); idle_req = 1'b0;
  endtask

  task automatic enter_deep();
    halt_req = 1'b1; step(1); halt_req = 1'b0;
  endtask

  // falling edge on the timer source, then return after 3 rising edges
  task automatic deep_exit(input logic exp_pulse, input string req);
    tbt_src = 1'b0;
    step(2);
    chk({req, " enables before sync"}, en3(), 3'b001);
    step(1);
    chk({req, " enables after exit"}, en3(), 3'b111);
    chk("R9 pulse", int'(tbt_set), int'(exp_pulse));
    chk("R5 resume deep", int'(resume), int'(imf));
    step(1);
    chk("R9 pulse drop", int'(tbt_set), 0);
    tbt_src = 1'b1;
    step(3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk("R1 reset enables", en3(), 3'b111);
    chk("R1 reset pulse", int'(tbt_set), 0);
    chk("R1 reset resume", int'(resume), 0);
    rst_n = 1'b1;

    // R2: strobe on the k-th sampled cycle when k%4==3
    bad = 0;
    for (int k = 1; k <= 40; k++) begin
      step(1);
      if (int'(mcyc) != ((k % 4 == 3) ? 1 : 0)) bad++;
    end
    chk("R2 strobe pattern mismatches", bad, 0);
    chk("R1 enables after release", en3(), 3'b111);
    step(3);

    // R3/R4/R5 sweep: imf x each irq bit
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < NUM_IRQ; b++) begin
        imf = m[0];
        enter_light();
        chk("R3 light enables", en3(), 3'b011);
        step(2);
        chk("R4 light holds without irq", en3(), 3'b011);
        irq[b] = 1'b1;
        step(1);
        irq = '0;
        chk("R4 wake on irq", en3(), 3'b111);
        chk("R5 resume light", int'(resume), m);
        exp_resume = m[0];
        imf = ~imf;
        step(1);
        chk("R5 resume held", int'(resume), int'(exp_resume));
      end
    end

    // R4: pending on entry -> one cycle of light idle
    irq = 4'b0100; imf = 1'b1;
    enter_light();
    chk("R4 pending entry light", en3(), 3'b011);
    step(1);
    chk("R4 pending entry wake", en3(), 3'b111);
    irq = '0;
    step(1);

    // R11: halt strobe during light ignored
    imf = 1'b0;
    enter_light();
    halt_req = 1'b1; step(1); halt_req = 1'b0;
    chk("R11 halt ignored in light", en3(), 3'b011);
    irq = 4'b0001; step(1); irq = '0;
    chk("R11 light wake", en3(), 3'b111);

    // R6/R7/R8/R9 sweep over timer enable at entry and later flip
    for (int e = 0; e < 2; e++) begin
      for (int f = 0; f < 2; f++) begin
        tbt_en = e[0];
        imf = f[0];
        enter_deep();
        chk("R6 deep enables", en3(), 3'b001);
        tbt_en = ~tbt_en;
        irq = '1;
        step(3);
        chk("R7 irq no wake in deep", en3(), 3'b001);
        irq = '0;
        deep_exit(e[0], "R8");
      end
    end

    // R7: rising edge only, and low level at entry, do not wake
    tbt_en = 1'b1;
    tbt_src = 1'b0; step(4);
    enter_deep();
    step(4);
    chk("R7 low level no wake", en3(), 3'b001);
    tbt_src = 1'b1;
    step(4);
    chk("R7 rising edge no wake", en3(), 3'b001);
    // R11: strobes ignored in deep
    idle_req = 1'b1; halt_req = 1'b1; step(1); idle_req = 1'b0; halt_req = 1'b0;
    chk("R11 strobes ignored in deep", en3(), 3'b001);
    deep_exit(1'b1, "R7");

    // R10: both strobes together
    tbt_en = 1'b0;
    idle_req = 1'b1; halt_req = 1'b1; step(1); idle_req = 1'b0; halt_req = 1'b0;
    chk("R10 halt wins", en3(), 3'b001);
    deep_exit(1'b0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule